// File: doc/BRIEF.md
# Programmable-Resolution Time Tag Counter

This block keeps a 16-bit free-running count that other logic copies whenever it needs to stamp an event, such as the start or the end of a bus message. By default the count advances once every N pulses of a 1 µs reference tick. N is a power of two from 2 to 64, chosen by a three-bit resolution code. When a source-select bit is set, an asynchronous external tick advances the count instead. That tick is first brought into the system clock domain and edge-detected.

The host can overwrite the count at any time with a single-cycle write strobe. The new value shows on the output on the next clock. A write also restarts the prescaler, so the first increment after it comes one full resolution period later. Changing the resolution code restarts the prescaler in the same way and leaves the count untouched. The counter behaves the same in every operating mode of the surrounding controller. It wraps from 0xFFFF to 0x0000 and marks the wrap with a one-cycle flag.

Top module: `event_stamp_timer`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, count_o reads 0x0000 and wrap_o reads 0.
- R2: When wr_en_i is high at a rising clock edge, count_o shows wr_data_i after that edge. This holds even when an increment would have happened in the same cycle, because the write takes priority.
- R3: With src_ext_i low, the count rises by exactly one for every P reference ticks. P is set by res_sel_i: code 000 gives 2, 001 gives 4, 010 gives 8, 011 gives 16, 100 gives 32 and 101 gives 64. Between increments the count holds.
- R4: Codes 110 and 111 of res_sel_i behave exactly like code 101, so one increment per 64 reference ticks.
- R5: A host write clears the prescaler. A reference tick in the same cycle as the write is not counted, and the next increment comes on the P-th reference tick after the write.
- R6: An increment from 0xFFFF gives 0x0000. wrap_o is high for exactly the one cycle in which count_o first shows that 0x0000, and is low at every other time, including after a write of 0x0000.
- R7: With src_ext_i high, each rising edge of ext_tick_i adds one to the count, and ref_tick_i has no effect. The input passes two synchroniser flops and an edge register, so a level first sampled high at clock edge k shows as an increment after edge k+2.
- R8: In a cycle where res_sel_i differs from its value in the previous cycle, the prescaler is cleared, that cycle's reference tick is not counted, and count_o keeps its value.
- R9: With src_ext_i low, activity on ext_tick_i does not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse every 1 µs, synchronous to clk |
| ext_tick_i | input | 1 | Asynchronous external count clock |
| res_sel_i | input | 3 | Resolution code (see R3, R4) |
| src_ext_i | input | 1 | 1 = count external tick edges, 0 = count prescaled reference |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Value loaded by a host write |
| count_o | output | 16 | Current count value |
| wrap_o | output | 1 | One-cycle pulse when the count wraps to zero |

## Verification
The bench targets four corner cases:
- A write that lands in the very cycle the prescaler would fire. A design that let the increment win would show the written value plus one.
- Ticks that arrive right after a write or after a resolution change. A prescaler that was not cleared would advance early and stamp events a fraction of a period off.
- The run across 0xFFFF, in both source modes and right after host writes near the top. A wrong design would drop or duplicate the wrap pulse, or leave it high for two cycles.
- The external path, driven with slow and fast edges. A design that counted levels instead of edges, or skipped a synchroniser stage, would run fast or advance one clock early.

// File: rtl/stamp_pkg.sv
// Package: shared widths and the resolution decode for the time tag counter.
// Assumes the resolution field is three bits and the largest period is 64.
package stamp_pkg;
    localparam int SEL_W = 3;                 // resolution code width
    localparam int PRE_W = 6;                 // prescaler width, holds 0..63
    localparam logic [SEL_W-1:0] TOP_CODE = 3'd5;  // last code with its own period

    // Returns the prescaler terminal value (period minus one) for a code.
    function automatic logic [PRE_W-1:0] last_of(input logic [SEL_W-1:0] code);
        logic [PRE_W:0] span;
        logic [SEL_W-1:0] eff;
        eff  = (code > TOP_CODE) ? TOP_CODE : code;
        span = (PRE_W+1)'(2) << eff;
        return PRE_W'(span - (PRE_W+1)'(1));
    endfunction
endpackage

// File: rtl/stamp_edge_sync.sv
// Module: stamp_edge_sync
// Brings an asynchronous level into the clk domain through STAGES flops,
// then emits a one-cycle pulse on each rising edge of the synchronised level.
// Assumes the input stays at each level for at least two clk periods so that
// no edge is lost.
module stamp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain: stage 0 samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    // Holds the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/stamp_prescaler.sv
// Module: stamp_prescaler
// Divides the 1 us reference tick by a power of two picked by a code.
// It is restarted by an external clear and by any change of the code;
// a tick in a restart cycle is dropped.
// Assumes ref_tick_i is a single-cycle pulse synchronous to clk.
module stamp_prescaler
    import stamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clr_i,
    output logic             adv_o
);
    logic [SEL_W-1:0] sel_q;
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] term;
    logic             restart;

    assign term    = last_of(sel_i);
    assign restart = clr_i | (sel_i != sel_q);
    assign adv_o   = tick_i & ~restart & (div_q == term);

    // Remembers last cycle's code so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_i;
    end

    // Reference tick divider: restarts on clear or code change, wraps at term.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (restart)          div_q <= '0;
        else if (tick_i) begin
            if (div_q == term)     div_q <= '0;
            else                   div_q <= div_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/stamp_count_core.sv
// Module: stamp_count_core
// Holds the count. A host load has priority over an advance.
// An advance from all-ones wraps to zero and raises a one-cycle wrap flag.
// Assumes adv_i and wr_i are synchronous to clk.
module stamp_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt_q;
    logic         wrap_q;

    // Count register: load first, then advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_i)  cnt_q <= wr_data_i;
        else if (adv_i) cnt_q <= cnt_q + W'(1);
    end

    // Wrap flag: high for the single cycle after an advance from all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= ~wr_i & adv_i & (cnt_q == ALL_ONES);
    end

    assign count_o = cnt_q;
    assign wrap_o  = wrap_q;
endmodule

// File: rtl/event_stamp_timer.sv
// Module: event_stamp_timer (top)
// 16-bit time tag counter. The count advances from a prescaled 1 us
// reference, or from a synchronised external tick when src_ext_i is set.
// It accepts host loads at once and flags a wrap to zero.
// Assumes ref_tick_i is a single-cycle pulse and that ext_tick_i
// changes no faster than the synchroniser can follow.
module event_stamp_timer
    import stamp_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick_i,
    input  logic             ext_tick_i,
    input  logic [SEL_W-1:0] res_sel_i,
    input  logic             src_ext_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic ref_adv;
    logic ext_adv;
    logic adv;

    stamp_prescaler presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (ref_tick_i),
        .sel_i  (res_sel_i),
        .clr_i  (wr_en_i),
        .adv_o  (ref_adv)
    );

    stamp_edge_sync #(.STAGES(SYNC_DEPTH)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_tick_i),
        .rise_o  (ext_adv)
    );

    // Source select between prescaled reference and external edges.
    always_comb begin
        adv = src_ext_i ? ext_adv : ref_adv;
    end

    stamp_count_core #(.W(CNT_W)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .wr_i      (wr_en_i),
        .wr_data_i (wr_data_i),
        .count_o   (count_o),
        .wrap_o    (wrap_o)
    );
endmodule

// File: rtl/stamp_timer_checker.sv
// Module: stamp_timer_checker
// Temporal properties of event_stamp_timer, attached by bind.
// Assumes the same clock and reset as the top module.
module stamp_timer_checker
    import stamp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] res_sel_i,
    input logic             src_ext_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             wrap_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !wrap_o));

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wr_data_i) && !wrap_o));

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

    assert_wrap_shows_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (count_o == '0));

    assert_wrap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

    assert_sel_change_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_sel_i != $past(res_sel_i) && !wr_en_i && !src_ext_i) |=> (count_o == $past(count_o)));
endmodule

bind event_stamp_timer stamp_timer_checker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/event_stamp_timer_tb.sv
// Bench for event_stamp_timer: seeded random stimulus plus directed corner
// cases. Every cycle is compared against a reference model built from the
// requirements.
module event_stamp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_i = 1'b0;
    logic        ext_tick_i = 1'b0;
    logic [2:0]  res_sel_i = 3'd0;
    logic        src_ext_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = 16'h0;
    logic [15:0] count_o;
    logic        wrap_o;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // model state
    logic [15:0] m_cnt = 0;
    logic        m_wrap = 0;
    logic [5:0]  m_div = 0;
    logic [2:0]  m_sel = 0;
    logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;

    always #4 clk = ~clk;   // 125 MHz

    event_stamp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .ext_tick_i(ext_tick_i),
        .res_sel_i(res_sel_i), .src_ext_i(src_ext_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .count_o(count_o), .wrap_o(wrap_o)
    );

    // Ticks per increment per R3 and R4.
    function automatic int period_of(input logic [2:0] code);
        case (code)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            default: return 64;
        endcase
    endfunction

    // Advances the model by one clock, then checks the outputs at the negedge.
    task automatic step();
        logic [15:0] n_cnt;
        logic        n_wrap;
        logic [5:0]  n_div;
        logic        restart, padv, eadv, adv;
        int          last;
        last    = period_of(res_sel_i) - 1;
        restart = wr_en_i || (res_sel_i != m_sel);
        padv    = ref_tick_i && !restart && (int'(m_div) == last);
        eadv    = m_s2 && !m_s3;
        adv     = src_ext_i ? eadv : padv;
        if (restart)         n_div = 0;
        else if (ref_tick_i) n_div = (int'(m_div) == last) ? 6'd0 : m_div + 6'd1;
        else                 n_div = m_div;
        if (wr_en_i)  begin n_cnt = wr_data_i; n_wrap = 0; end
        else if (adv) begin n_cnt = m_cnt + 16'd1; n_wrap = (m_cnt == 16'hFFFF); end
        else          begin n_cnt = m_cnt; n_wrap = 0; end
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_wrap = 0; m_div = 0; m_sel = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_tick_i;
            m_cnt = n_cnt; m_wrap = n_wrap; m_div = n_div; m_sel = res_sel_i;
        end
        @(negedge clk);
        n_vec++;
        if (count_o !== m_cnt || wrap_o !== m_wrap) begin
            n_bad++;
            $display("FAIL %s: count=%h wrap=%b expected count=%h wrap=%b",
                     tag, count_o, wrap_o, m_cnt, m_wrap);
        end
    endtask

    // Random resolution phase for one code (R3, R4, R9).
    task automatic run_code(input logic [2:0] code, input int cycles);
        res_sel_i = code;
        src_ext_i = 0;
        for (int i = 0; i < cycles; i++) begin
            ref_tick_i = ($urandom % 4) != 0;
            ext_tick_i = $urandom % 2;          // must be ignored: R9
            wr_en_i    = ($urandom % 700) == 0;
            wr_data_i  = 16'($urandom);
            step();
        end
        wr_en_i = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state, held for a few cycles
        tag = "R1";
        for (int i = 0; i < 4; i++) step();
        rst_n = 1;
        step();

        // R3: each defined code; R4: the two unused codes
        for (int c = 0; c < 8; c++) begin
            tag = (c <= 5) ? "R3 R9" : "R4";
            run_code(3'(c), 2500);
        end

        // R2: frequent writes against a prescaler firing on every other tick
        tag = "R2"; res_sel_i = 0; src_ext_i = 0;
        for (int i = 0; i < 600; i++) begin
            ref_tick_i = 1;
            wr_en_i    = ($urandom % 3) == 0;
            wr_data_i  = 16'($urandom);
            step();
        end

        // R5: write then count exactly one period of ticks
        tag = "R5"; res_sel_i = 3'd1;
        for (int k = 0; k < 40; k++) begin
            ref_tick_i = 1; wr_en_i = 1; wr_data_i = 16'(k * 97);
            step();
            wr_en_i = 0;
            for (int j = 0; j < 3 + (k % 6); j++) begin
                ref_tick_i = (j % 2 == 0) || (k % 3 == 0);
                step();
            end
        end

        // R6: directed wrap from both sources
        tag = "R6"; res_sel_i = 0; src_ext_i = 0;
        wr_en_i = 1; wr_data_i = 16'hFFFC; step(); wr_en_i = 0;
        for (int i = 0; i < 30; i++) begin ref_tick_i = 1; step(); end
        wr_en_i = 1; wr_data_i = 16'h0000; ref_tick_i = 0; step(); wr_en_i = 0;
        step(); step();
        src_ext_i = 1; wr_en_i = 1; wr_data_i = 16'hFFFE; step(); wr_en_i = 0;
        for (int i = 0; i < 40; i++) begin ext_tick_i = (i % 6) < 3; step(); end

        // R7: external source, slow edges then fast random levels
        tag = "R7"; src_ext_i = 1;
        for (int i = 0; i < 1500; i++) begin
            if ($urandom % 4 == 0) ext_tick_i = ~ext_tick_i;
            ref_tick_i = $urandom % 2;
            wr_en_i    = ($urandom % 400) == 0;
            wr_data_i  = 16'($urandom);
            step();
        end
        for (int i = 0; i < 500; i++) begin
            ext_tick_i = $urandom % 2; ref_tick_i = 1; wr_en_i = 0;
            step();
        end

        // R8: resolution changes mid-count
        tag = "R8"; src_ext_i = 0; ext_tick_i = 0;
        for (int i = 0; i < 3000; i++) begin
            ref_tick_i = ($urandom % 5) != 0;
            if ($urandom % 25 == 0) res_sel_i = 3'($urandom);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: count=%h wrap=%b expected run to end", count_o, wrap_o);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule